// File: doc/BRIEF.md
# Logic Analyzer Trigger Unit

This block watches a 32-channel sample word, organised as four groups of eight channels, and decides when a capture should be triggered. Software programs it through a byte-wide write port. Eight bytes hold the level condition for each channel: high, low or don't-care. One byte picks an optional edge condition on a single channel: rising, falling or either. Two further bytes hold a 16-bit occurrence count. A sample qualifies when every enabled level condition holds and, if an edge condition is set, the chosen channel has the programmed edge between the previous valid sample and this one. The unit counts qualifying samples. On the qualifying sample that brings the count to the programmed value, it emits a one-cycle trigger pulse and latches.

The controller has two states. In `ST_HUNT` it counts qualifying samples. It moves to `ST_FIRED` on the qualifying sample that reaches the count, and this transition produces the pulse. `ST_FIRED` ignores samples and returns to `ST_HUNT` only when `arm` is high. Reset also leaves the unit in `ST_HUNT`.

Top module: `trg_unit`

## Requirements
- R1: After reset, all level bytes and the edge byte read as zero (no condition) and the count is 1. The unit is hunting with `trig_pulse` and `trig_hit` low, so the first valid sample fires.
- R2: Channel c = 8·group + position (group A=0, B=1, C=2, D=3) is controlled by level byte c/4, at write address c/4 (0–7). Within that byte, bit 2·(c mod 4) requires the channel to be high and bit 2·(c mod 4)+1 requires it to be low.
- R3: A channel with both level bits clear is don't-care. A channel with both level bits set can never qualify.
- R4: The edge byte is at address 8. Bits 7:6 select the edge: 00 none, 01 rising, 10 falling, 11 either. Bits 4:0 hold the channel index 8·group + position.
- R5: An edge compares the chosen channel in the previous valid sample with the current one. The first valid sample after reset or after `arm` has no history and cannot satisfy an edge condition.
- R6: The count low byte is at address 9 and the high byte at address 10. The unit fires on the Nth qualifying sample counted since the unit began hunting, and non-qualifying samples do not count. A count of 0 behaves as 1.
- R7: `trig_pulse` is high for exactly one cycle, the cycle after the edge that took the final qualifying sample. `trig_hit` rises in that same cycle and stays high until `arm` is seen.
- R8: While fired, valid samples produce no pulse and do not advance the count.
- R9: `arm` returns the unit to hunting, clears the count and the edge history, and wins over a sample in the same cycle. That sample is neither counted nor kept as history.
- R10: Samples with `smp_valid` low are ignored. A register write takes effect from the next cycle, so a sample in the same cycle as a write is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0–7 level, 8 edge, 9–10 count) |
| cfg_wdata | input | 8 | Register write data |
| arm | input | 1 | Clear latch, count and history; resume hunting |
| smp_valid | input | 1 | Sample word is valid this cycle |
| smp_data | input | 32 | Sample word, channel c on bit c |
| trig_pulse | output | 1 | One-cycle trigger event |
| trig_hit | output | 1 | Latched trigger flag (state `ST_FIRED`) |

## Verification
The bench tests two cases where two events fall in one cycle. The first is `arm` together with a valid sample. With a count of two, one sample is counted, then `arm` arrives with a sample, and the bench requires two further samples before the pulse. With a rising-edge condition, a low sample taken with `arm` must not serve as history for a following high sample. The second case is a configuration write together with a sample: a sample that breaks the newly written level condition must still fire, because it is judged against the old settings.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_FIRED = 1'b1
    } trg_state_e;

    typedef enum logic [1:0] {
        EDG_NONE = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_ANY  = 2'b11
    } edge_mode_e;

endpackage

// File: rtl/trg_cfg_regs.sv
module trg_cfg_regs #(
    parameter int NUM_CH = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [2*NUM_CH-1:0] lvl_mask,
    output logic [7:0]          edge_sel,
    output logic [CNT_W-1:0]    occ_count
);
    localparam int LVL_BYTES = (2 * NUM_CH) / 8;
    localparam int CNT_BYTES = CNT_W / 8;
    localparam int EDGE_ADDR = LVL_BYTES;
    localparam int CNT_ADDR  = LVL_BYTES + 1;

    genvar b;
    generate
        for (b = 0; b < LVL_BYTES; b++) begin : g_lvl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    lvl_mask[8*b +: 8] <= 8'h00;
                else if (we && (int'(addr) == b))
                    lvl_mask[8*b +: 8] <= wdata;
            end
        end
        for (b = 0; b < CNT_BYTES; b++) begin : g_cnt
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    occ_count[8*b +: 8] <= (b == 0) ? 8'h01 : 8'h00;
                else if (we && (int'(addr) == CNT_ADDR + b))
                    occ_count[8*b +: 8] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            edge_sel <= 8'h00;
        else if (we && (int'(addr) == EDGE_ADDR))
            edge_sel <= wdata;
    end

    // R10: a write changes only the addressed byte, one cycle later
    p_edge_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (int'(addr) == EDGE_ADDR)) |=> $stable(edge_sel));

endmodule

// File: rtl/trg_match.sv
module trg_match
    import trg_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                smp_valid,
    input  logic [NUM_CH-1:0]   smp_data,
    input  logic [2*NUM_CH-1:0] lvl_mask,
    input  logic [7:0]          edge_sel,
    output logic                qual
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [NUM_CH-1:0] prev_data;
    logic              prev_ok;
    logic [NUM_CH-1:0] ch_ok;
    logic              lvl_ok;
    logic              edge_ok;
    logic              cur_bit;
    logic              old_bit;
    logic [IDX_W-1:0]  edge_idx;
    edge_mode_e        edge_mode;

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            assign ch_ok[c] = !(lvl_mask[2*c]   && !smp_data[c]) &&
                              !(lvl_mask[2*c+1] &&  smp_data[c]);
        end
    endgenerate

    assign lvl_ok    = &ch_ok;
    assign edge_idx  = edge_sel[IDX_W-1:0];
    assign edge_mode = edge_mode_e'(edge_sel[7:6]);
    assign cur_bit   = smp_data[edge_idx];
    assign old_bit   = prev_data[edge_idx];

    always_comb begin
        unique case (edge_mode)
            EDG_NONE: edge_ok = 1'b1;
            EDG_RISE: edge_ok = prev_ok && !old_bit &&  cur_bit;
            EDG_FALL: edge_ok = prev_ok &&  old_bit && !cur_bit;
            EDG_ANY:  edge_ok = prev_ok && (old_bit != cur_bit);
            default:  edge_ok = 1'b0;
        endcase
    end

    assign qual = smp_valid && lvl_ok && edge_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_data <= '0;
            prev_ok   <= 1'b0;
        end else if (arm) begin
            prev_ok   <= 1'b0;
        end else if (smp_valid) begin
            prev_data <= smp_data;
            prev_ok   <= 1'b1;
        end
    end

    // R5: no edge can qualify without a history sample
    p_edge_hist_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel[7:6] != 2'b00 && !prev_ok) |-> !qual);
    // R9: arm wipes history
    p_arm_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !prev_ok);

endmodule

// File: rtl/trg_ctrl.sv
module trg_ctrl
    import trg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             qual,
    input  logic [CNT_W-1:0] occ_count,
    output logic             trig_pulse,
    output logic             trig_hit
);
    trg_state_e       state, state_nxt;
    logic [CNT_W-1:0] hit_cnt;
    logic [CNT_W-1:0] eff_count;
    logic             last_hit;
    logic             fire;

    assign eff_count = (occ_count == '0) ? CNT_W'(1) : occ_count;
    assign last_hit  = ({1'b0, hit_cnt} + 1'b1) >= {1'b0, eff_count};
    assign fire      = (state == ST_HUNT) && !arm && qual && last_hit;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT:  if (fire) state_nxt = ST_FIRED;
            ST_FIRED: if (arm)  state_nxt = ST_HUNT;
            default:            state_nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HUNT;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hit_cnt <= '0;
        else if (arm || state != ST_HUNT || fire)
            hit_cnt <= '0;
        else if (qual)
            hit_cnt <= hit_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trig_pulse <= 1'b0;
        else
            trig_pulse <= fire;
    end

    assign trig_hit = (state == ST_FIRED);

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    p_pulse_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> trig_hit);
    p_hit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !arm) |=> trig_hit);
    p_rise_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_hit) |-> trig_pulse);
    p_arm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!trig_hit && !trig_pulse));
    p_fired_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> !trig_pulse);

endmodule

// File: rtl/trg_unit.sv
module trg_unit #(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 8,
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [7:0]                    cfg_wdata,
    input  logic                          arm,
    input  logic                          smp_valid,
    input  logic [NUM_GROUPS*GROUP_W-1:0] smp_data,
    output logic                          trig_pulse,
    output logic                          trig_hit
);
    localparam int NUM_CH = NUM_GROUPS * GROUP_W;

    logic [2*NUM_CH-1:0] lvl_mask;
    logic [7:0]          edge_sel;
    logic [CNT_W-1:0]    occ_count;
    logic                qual;

    trg_cfg_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .lvl_mask  (lvl_mask),
        .edge_sel  (edge_sel),
        .occ_count (occ_count)
    );

    trg_match #(.NUM_CH(NUM_CH)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .lvl_mask  (lvl_mask),
        .edge_sel  (edge_sel),
        .qual      (qual)
    );

    trg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .qual       (qual),
        .occ_count  (occ_count),
        .trig_pulse (trig_pulse),
        .trig_hit   (trig_hit)
    );

    // R10: an invalid sample never causes a pulse
    p_invalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !trig_pulse);

endmodule

// File: tb/sim_trg_unit.sv
`timescale 1ns/100ps
module sim_trg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        trig_pulse;
    logic        trig_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trg_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .trig_pulse(trig_pulse), .trig_hit(trig_hit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic v, input logic [31:0] d, input logic a,
                       input logic w, input logic [3:0] ad, input logic [7:0] wd);
        @(negedge clk);
        smp_valid = v; smp_data = d; arm = a;
        cfg_we = w; cfg_addr = ad; cfg_wdata = wd;
        @(posedge clk);
        #1;
        smp_valid = 1'b0; arm = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic smp(input logic [31:0] d);
        cyc(1'b1, d, 1'b0, 1'b0, 4'd0, 8'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        cyc(1'b0, 32'd0, 1'b0, 1'b1, a, v);
    endtask

    task automatic do_arm();
        cyc(1'b0, 32'd0, 1'b1, 1'b0, 4'd0, 8'd0);
    endtask

    task automatic t_reset();
        chk("R1 pulse after reset", trig_pulse, 1'b0);
        chk("R1 hit after reset", trig_hit, 1'b0);
        cyc(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'd0, 8'd0);
        chk("R10 invalid sample ignored", trig_pulse, 1'b0);
        smp(32'h1234_5678);
        chk("R1 first sample fires", trig_pulse, 1'b1);
        chk("R7 hit with pulse", trig_hit, 1'b1);
        cyc(1'b0, 32'd0, 1'b0, 1'b0, 4'd0, 8'd0);
        chk("R7 pulse one cycle", trig_pulse, 1'b0);
        chk("R7 hit latched", trig_hit, 1'b1);
        smp(32'h0);
        chk("R8 fired ignores sample", trig_pulse, 1'b0);
        do_arm();
        chk("R9 arm clears hit", trig_hit, 1'b0);
    endtask

    task automatic t_level();
        wr(4'd5, 8'h04);            // R2 group C pos 5 -> ch21 high
        smp(32'h0);
        chk("R2 ch21 high unmet", trig_pulse, 1'b0);
        smp(32'h0020_0000);
        chk("R2 ch21 high met", trig_pulse, 1'b1);
        do_arm(); wr(4'd5, 8'h00);
        wr(4'd0, 8'h08);            // ch1 low
        smp(32'h2);
        chk("R2 ch1 low unmet", trig_pulse, 1'b0);
        smp(32'h0);
        chk("R2 ch1 low met", trig_pulse, 1'b1);
        do_arm(); wr(4'd0, 8'h00);
    endtask

    task automatic t_both();
        wr(4'd7, 8'hC0);            // ch31 both bits
        smp(32'h0);
        chk("R3 both set, ch31=0", trig_pulse, 1'b0);
        smp(32'h8000_0000);
        chk("R3 both set, ch31=1", trig_pulse, 1'b0);
        wr(4'd7, 8'h00);
        smp(32'h0000_5A5A);
        chk("R3 dont-care fires", trig_pulse, 1'b1);
        do_arm();
    endtask

    task automatic t_edge();
        wr(4'd8, 8'h4A); do_arm();  // rising ch10
        smp(32'h400);
        chk("R5 no history after arm", trig_pulse, 1'b0);
        smp(32'h400);
        chk("R4 rising steady high", trig_pulse, 1'b0);
        smp(32'h0);
        chk("R4 rising sees fall", trig_pulse, 1'b0);
        smp(32'h400);
        chk("R4 rising edge", trig_pulse, 1'b1);
        do_arm(); wr(4'd8, 8'h8A); do_arm();   // falling ch10
        smp(32'h400);
        chk("R5 falling first sample", trig_pulse, 1'b0);
        smp(32'h0);
        chk("R4 falling edge", trig_pulse, 1'b1);
        do_arm(); wr(4'd8, 8'hDF); do_arm();   // either ch31
        smp(32'h0);
        smp(32'h0);
        chk("R4 either no change", trig_pulse, 1'b0);
        smp(32'h8000_0000);
        chk("R4 either rise", trig_pulse, 1'b1);
        do_arm();
        smp(32'h8000_0000);
        chk("R5 history cleared by arm", trig_pulse, 1'b0);
        smp(32'h0);
        chk("R4 either fall", trig_pulse, 1'b1);
        do_arm(); wr(4'd8, 8'h1F);             // mode none
        smp(32'h0);
        chk("R4 mode none fires", trig_pulse, 1'b1);
        do_arm(); wr(4'd8, 8'h00);
    endtask

    task automatic t_count();
        bit seen;
        wr(4'd9, 8'd3); wr(4'd0, 8'h01);       // count 3, ch0 high
        smp(32'h1); chk("R6 first of three", trig_pulse, 1'b0);
        smp(32'h0); chk("R6 non-qualifying", trig_pulse, 1'b0);
        smp(32'h1); chk("R6 second of three", trig_pulse, 1'b0);
        smp(32'h0);
        smp(32'h1); chk("R6 third fires", trig_pulse, 1'b1);
        do_arm(); wr(4'd0, 8'h00);
        wr(4'd9, 8'd0); wr(4'd10, 8'd1);       // count 256
        seen = 1'b0;
        for (int i = 0; i < 255; i++) begin
            smp(32'(i));
            if (trig_pulse) seen = 1'b1;
        end
        chk("R6 no fire before 256", seen, 1'b0);
        smp(32'h0);
        chk("R6 fires at 256", trig_pulse, 1'b1);
        do_arm(); wr(4'd10, 8'd0);             // count 0
        smp(32'h0);
        chk("R6 count zero as one", trig_pulse, 1'b1);
        do_arm(); wr(4'd9, 8'd1);
    endtask

    task automatic t_same();
        wr(4'd9, 8'd2);
        smp(32'h0);
        chk("R6 one of two", trig_pulse, 1'b0);
        cyc(1'b1, 32'h0, 1'b1, 1'b0, 4'd0, 8'd0);
        chk("R9 arm beats sample", trig_pulse, 1'b0);
        smp(32'h0);
        chk("R9 arm-cycle sample not counted", trig_pulse, 1'b0);
        smp(32'h0);
        chk("R9 fires after two new", trig_pulse, 1'b1);
        do_arm(); wr(4'd9, 8'd1);
        wr(4'd8, 8'h41); do_arm();             // rising ch1
        smp(32'h0);
        cyc(1'b1, 32'h0, 1'b1, 1'b0, 4'd0, 8'd0);
        smp(32'h2);
        chk("R9 arm-cycle sample not history", trig_pulse, 1'b0);
        smp(32'h0);
        smp(32'h2);
        chk("R9 rising after fresh history", trig_pulse, 1'b1);
        do_arm(); wr(4'd8, 8'h00);
        cyc(1'b1, 32'h0, 1'b0, 1'b1, 4'd0, 8'h01);
        chk("R10 same-cycle write uses old", trig_pulse, 1'b1);
        do_arm();
        smp(32'h0);
        chk("R10 new setting applies", trig_pulse, 1'b0);
        smp(32'h1);
        chk("R10 new setting met", trig_pulse, 1'b1);
        do_arm(); wr(4'd0, 8'h00);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_level();
        t_both();
        t_edge();
        t_count();
        t_same();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

endmodule